// File: doc/BRIEF.md
# Four-Lane Parallel CRC-32 Engine

This block computes the 32-bit cyclic redundancy check used for Ethernet frames and ATM cells. It works on a byte stream that arrives four bytes per clock on four byte lanes. Each lane has eight data bits and one control flag. The engine takes in one whole 32-bit word on every clock cycle. When the packet ends it closes the ragged last word, which may hold one, two, three or four bytes, and then presents the frame check value for one cycle together with a strobe.

The running remainder is kept in augmented form. At the start of a packet the state register is loaded with a start value that is not all-ones. This value is computed at elaboration so that the final remainder matches the usual all-ones-preset CRC-32. With this form each step of the loop only shifts data in and folds the polynomial back. The price is one extra cycle, in which 32 zero bits are pushed through the engine after the data.

Four update networks, for one, two, three and four bytes, all work on the same word in parallel. The lane flags pick which of their outputs is kept. A three-state sequencer steps through idle, body and padding.

Top module: `crc32q_engine`

## Requirements
- R1: The value on `result` is the standard CRC-32 of the packet bytes. This is the CRC with generator polynomial 0x04C11DB7, an all-ones preset, bytes taken least significant bit first, and the final register bit-reflected and inverted. The nine ASCII bytes "123456789" give 0xCBF43926.
- R2: Lane k carries data on `lane_data[8k+7:8k]` and its flag on `lane_ctl[k]`, where 0 means data. Lane 0 holds the earliest byte. A word with all four flags at 0 adds four bytes to the packet in one cycle.
- R3: The lowest lane whose flag is 1 ends the packet. Only the lanes below it count, so the final word holds 1, 2 or 3 bytes. Flags and data on the lanes at and above the ending lane have no effect on the result.
- R4: A packet whose length is a multiple of four ends with a word whose lane 0 flag is 1. That word adds no bytes.
- R5: `result_valid` is a pulse exactly one cycle wide. It is high during the third clock cycle after the cycle in which the ending word is driven. That is two rising edges after the edge that captures the ending word.
- R6: The word presented in the cycle right after the ending word is ignored, even if its lane 0 flag is 0. It starts no packet and causes no pulse.
- R7: The first word of the next packet may be presented two cycles after the ending word. Its absorption then falls in the same cycle as the previous packet's result pulse, and both values are correct.
- R8: When no packet is in progress, words with the lane 0 flag at 1 are idle. `result` holds the last value and `result_valid` stays low.
- R9: While `rst_n` is low, `result` is 0 and `result_valid` is low.
- R10: A reset in the middle of a packet throws that packet away. The next packet is computed from a fresh start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_ctl | input | 4 | Per-lane control flags, 1 marks a non-data lane |
| lane_data | input | 32 | Four data bytes, lane 0 in bits 7:0 |
| result | output | 32 | Frame check value of the last finished packet |
| result_valid | output | 1 | One-cycle strobe for a new `result` |

## Verification
Two things can happen in the same cycle: the padding of one packet finishes and its result is emitted, and the next packet's first word is loaded into the state register from the modified start value. The bench provokes this by driving packets back to back. It puts one ignored word after the first packet's ending word and then drives the first word of the second packet straight away. The check passes only if the first result arrives in its exact cycle with the right value and the second packet's CRC is also right. A wrong second CRC means the start value or the register enable was disturbed by the overlap.

// File: rtl/crc32q_pkg.sv
package crc32q_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 32;

  localparam logic [CRC_W-1:0] ETH_POLY        = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] ETH_DIRECT_INIT = 32'hFFFF_FFFF;

  typedef logic [CRC_W-1:0] crc_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_PAD  = 2'd2
  } seq_t;

  // Augmented remainder step: message bit enters at the low end,
  // the bit leaving the top folds the polynomial back in.
  function automatic crc_t aug_shift_bit(input crc_t r, input logic b, input crc_t poly);
    crc_t nx;
    nx = {r[CRC_W-2:0], b};
    if (r[CRC_W-1]) nx = nx ^ poly;
    return nx;
  endfunction

  // Inverse of CRC_W zero-bit steps: gives the start value S whose
  // CRC_W-bit zero padding lands on the requested direct preset.
  function automatic crc_t undo_zero_shifts(input crc_t target, input crc_t poly);
    crc_t r;
    logic top;
    r = target;
    for (int i = 0; i < CRC_W; i++) begin
      top = r[0];
      if (top) r = r ^ poly;
      r = {top, r[CRC_W-1:1]};
    end
    return r;
  endfunction

  function automatic crc_t reflect_crc(input crc_t v);
    crc_t o;
    for (int i = 0; i < CRC_W; i++) o[i] = v[CRC_W-1-i];
    return o;
  endfunction

endpackage

// File: rtl/crc32q_update.sv
module crc32q_update
  import crc32q_pkg::*;
#(
  parameter int   NB   = 4,
  parameter crc_t POLY = ETH_POLY
) (
  input  crc_t                   crc_in,
  input  logic [NB*BYTE_W-1:0]   bytes_in,
  output crc_t                   crc_out
);

  // Bytes in lane order, each least significant bit first.
  always_comb begin
    crc_t r;
    r = crc_in;
    for (int b = 0; b < NB; b++) begin
      for (int j = 0; j < BYTE_W; j++) begin
        r = aug_shift_bit(r, bytes_in[b*BYTE_W+j], POLY);
      end
    end
    crc_out = r;
  end

endmodule

// File: rtl/crc32q_lane_decode.sv
module crc32q_lane_decode #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] ctl,
  output logic [LANES:0]   cnt_sel,
  output logic             term
);

  // cnt_sel[k] is set when exactly k leading lanes carry data.
  always_comb begin
    logic found;
    found   = 1'b0;
    cnt_sel = '0;
    for (int l = 0; l < LANES; l++) begin
      if (!found && ctl[l]) begin
        cnt_sel[l] = 1'b1;
        found      = 1'b1;
      end
    end
    if (!found) cnt_sel[LANES] = 1'b1;
    term = found;
  end

endmodule

// File: rtl/crc32q_ctrl.sv
module crc32q_ctrl
  import crc32q_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lead_ctl,
  input  logic term,
  output logic absorb,
  output logic use_preset,
  output logic finish
);

  seq_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (!lead_ctl) st_d = term ? ST_PAD : ST_BODY;
      ST_BODY: if (term)      st_d = ST_PAD;
      ST_PAD:                 st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  assign absorb     = (st_q != ST_PAD) && !lead_ctl;
  assign use_preset = (st_q == ST_IDLE);
  assign finish     = (st_q == ST_PAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R6: padding lasts one cycle and the next word is not examined.
  p_pad_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAD) |=> (st_q == ST_IDLE))
    else $error("pad state did not return to idle");

  // R8: idle words keep the sequencer idle.
  p_idle_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && lead_ctl) |=> (st_q == ST_IDLE))
    else $error("idle word left idle state");

endmodule

// File: rtl/crc32q_engine.sv
module crc32q_engine
  import crc32q_pkg::*;
#(
  parameter int   LANES       = 4,
  parameter crc_t POLY        = ETH_POLY,
  parameter crc_t DIRECT_INIT = ETH_DIRECT_INIT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          lane_ctl,
  input  logic [LANES*BYTE_W-1:0]   lane_data,
  output logic [CRC_W-1:0]          result,
  output logic                      result_valid
);

  localparam int   DATA_W   = LANES * BYTE_W;
  localparam int   PAD_NB   = CRC_W / BYTE_W;
  localparam int   PAD_W    = PAD_NB * BYTE_W;
  localparam crc_t AUG_INIT = undo_zero_shifts(DIRECT_INIT, POLY);

  // Input capture
  logic [LANES-1:0]  ctl_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '1;
      data_q <= '0;
    end else begin
      ctl_q  <= lane_ctl;
      data_q <= lane_data;
    end
  end

  // Lane decode and sequencing
  logic [LANES:0] cnt_sel;
  logic           term;
  logic           absorb, use_preset, finish;

  crc32q_lane_decode #(.LANES(LANES)) u_dec (
    .ctl     (ctl_q),
    .cnt_sel (cnt_sel),
    .term    (term)
  );

  crc32q_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lead_ctl   (ctl_q[0]),
    .term       (term),
    .absorb     (absorb),
    .use_preset (use_preset),
    .finish     (finish)
  );

  // Parallel update networks, one per possible byte count
  crc_t                    crc_q;
  crc_t                    base;
  logic [LANES:0][CRC_W-1:0] upd;

  assign base   = use_preset ? AUG_INIT : crc_q;
  assign upd[0] = base;

  for (genvar k = 1; k <= LANES; k++) begin : g_net
    crc32q_update #(.NB(k), .POLY(POLY)) u_net (
      .crc_in   (base),
      .bytes_in (data_q[k*BYTE_W-1:0]),
      .crc_out  (upd[k])
    );
  end

  crc_t crc_sel;
  always_comb begin
    crc_sel = '0;
    for (int k = 0; k <= LANES; k++) begin
      if (cnt_sel[k]) crc_sel = crc_sel | upd[k];
    end
  end

  // Zero padding network
  crc_t crc_pad;
  crc32q_update #(.NB(PAD_NB), .POLY(POLY)) u_pad (
    .crc_in   (crc_q),
    .bytes_in ({PAD_W{1'b0}}),
    .crc_out  (crc_pad)
  );

  // State and result registers with explicit enables
  crc_t crc_d, res_d;
  logic res_en;

  assign crc_d  = crc_sel;
  assign res_d  = ~reflect_crc(crc_pad);
  assign res_en = finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (absorb) crc_q <= crc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= res_en;
      if (res_en) result <= res_d;
    end
  end

  // R3: exactly one byte-count network is selected.
  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cnt_sel))
    else $error("byte count select not one-hot");

  // R5: strobe is a single-cycle pulse.
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid)
    else $error("result_valid longer than one cycle");

  // R5: strobe only follows a padding cycle.
  p_pulse_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(finish))
    else $error("result_valid without padding");

  // R8: result holds between strobes.
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result))
    else $error("result changed without strobe");

endmodule

// File: tb/sim_crc32q_engine.sv
`timescale 1ns/1ps
module sim_crc32q_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  lane_ctl;
  logic [31:0] lane_data;
  logic [31:0] result;
  logic        result_valid;

  always #2 clk = ~clk;  // 250 MHz

  crc32q_engine u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .lane_ctl     (lane_ctl),
    .lane_data    (lane_data),
    .result       (result),
    .result_valid (result_valid)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          pulse_n = 0;
  logic [31:0] pulse_val [0:63];
  int          pulse_cyc [0:63];
  always @(negedge clk) begin
    if (rst_n === 1'b1 && result_valid === 1'b1) begin
      if (pulse_n < 64) begin
        pulse_val[pulse_n] = result;
        pulse_cyc[pulse_n] = cyc;
      end
      pulse_n++;
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [7:0] pkt [0:63];

  task automatic fill(input int len, input logic [7:0] seed);
    for (int i = 0; i < 64; i++) pkt[i] = 8'(seed + i*37 + (i >> 2));
    if (len > 64) $display("bad length");
  endtask

  function automatic logic [31:0] ref_crc(input int len);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) begin
      c = c ^ {24'h0, pkt[i]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic drive(input logic [3:0] c, input logic [31:0] d);
    @(negedge clk);
    lane_ctl  = c;
    lane_data = d;
  endtask

  task automatic send_pkt(input int len, input logic [7:0] jseed, input bit follow_data,
                          input int gap, output int term);
    int nw;
    nw = len / 4 + 1;
    for (int w = 0; w < nw; w++) begin
      logic [3:0]  c;
      logic [31:0] d;
      c = 4'h0;
      d = 32'h0;
      for (int l = 0; l < 4; l++) begin
        int idx;
        idx = w*4 + l;
        if (idx < len) begin
          c[l] = 1'b0;
          d[l*8 +: 8] = pkt[idx];
        end else begin
          c[l] = (idx == len) ? 1'b1 : jseed[l];
          d[l*8 +: 8] = jseed ^ 8'hA5 ^ 8'(l);
        end
      end
      drive(c, d);
    end
    term = cyc;
    if (follow_data) drive(4'h0, 32'hC0FF_EE11);
    else             drive(4'hF, 32'h0707_0707);
    for (int g = 0; g < gap; g++) drive(4'hF, 32'h0707_0707);
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
    #1;
  endtask

  task automatic expect_pulse(input int idx, input int term, input logic [31:0] exp, input string tag);
    check_eq({tag, " pulse present"}, 32'(pulse_n > idx), 32'd1);
    if (pulse_n > idx && idx < 64) begin
      check_eq({tag, " value"}, pulse_val[idx], exp);
      check_eq({tag, " timing R5"}, 32'(pulse_cyc[idx]), 32'(term + 3));
    end
  endtask

  typedef struct packed {
    logic [7:0] len;
    logic [7:0] seed;
    logic       follow;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd1,  8'h11, 1'b0}, '{8'd2,  8'h5A, 1'b1}, '{8'd3,  8'hC3, 1'b0},
    '{8'd4,  8'h00, 1'b1}, '{8'd5,  8'hFF, 1'b0}, '{8'd6,  8'h3C, 1'b1},
    '{8'd7,  8'h96, 1'b0}, '{8'd8,  8'h71, 1'b0}, '{8'd13, 8'hE8, 1'b1},
    '{8'd16, 8'h2D, 1'b0}, '{8'd46, 8'hB4, 1'b1}, '{8'd64, 8'h69, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int term, term_a, base;
    logic [31:0] exp, exp_a, hold;
    rst_n     = 1'b0;
    lane_ctl  = 4'hF;
    lane_data = 32'h0707_0707;
    repeat (3) @(negedge clk);
    #1;
    check_eq("R9 reset result", result, 32'h0);
    check_eq("R9 reset valid", 32'(result_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) drive(4'hF, 32'h0707_0707);

    // Table of packets: R1, R2 full words, R3 partial last word, R4, R6
    for (int v = 0; v < NV; v++) begin
      fill(int'(VECS[v].len), VECS[v].seed);
      exp  = ref_crc(int'(VECS[v].len));
      base = pulse_n;
      send_pkt(int'(VECS[v].len), VECS[v].seed, VECS[v].follow, 3, term);
      wait_cyc(term + 6);
      if (VECS[v].len % 4 == 0) expect_pulse(base, term, exp, "R4 R2 R1");
      else                      expect_pulse(base, term, exp, "R3 R1");
      check_eq("R6 single pulse", 32'(pulse_n), 32'(base + 1));
    end

    // R1 anchor value
    for (int i = 0; i < 9; i++) pkt[i] = 8'h31 + 8'(i);
    base = pulse_n;
    send_pkt(9, 8'hF0, 1'b0, 3, term);
    wait_cyc(term + 5);
    expect_pulse(base, term, 32'hCBF4_3926, "R1 check value");

    // R8 idle hold
    hold = result;
    base = pulse_n;
    for (int i = 0; i < 6; i++) begin
      drive(4'hF - 4'(i & 1) * 4'h2, 32'h1234_5678 + 32'(i));
      #1;
      check_eq("R8 valid low while idle", 32'(result_valid), 32'h0);
    end
    wait_cyc(cyc + 3);
    check_eq("R8 result held", result, hold);
    check_eq("R8 no pulse", 32'(pulse_n), 32'(base));

    // R7 back-to-back: result of A and absorption of B in one cycle
    fill(11, 8'h4E);
    exp_a = ref_crc(11);
    base  = pulse_n;
    send_pkt(11, 8'h4E, 1'b0, 0, term_a);
    fill(8, 8'hD2);
    exp = ref_crc(8);
    send_pkt(8, 8'hD2, 1'b0, 3, term);
    wait_cyc(term + 5);
    expect_pulse(base, term_a, exp_a, "R7 first");
    expect_pulse(base + 1, term, exp, "R7 second");

    // R10 reset mid-packet
    fill(12, 8'h88);
    drive(4'h0, {pkt[3], pkt[2], pkt[1], pkt[0]});
    drive(4'h0, {pkt[7], pkt[6], pkt[5], pkt[4]});
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_eq("R9 result cleared", result, 32'h0);
    check_eq("R9 valid cleared", 32'(result_valid), 32'h0);
    repeat (2) @(negedge clk);
    lane_ctl = 4'hF;
    rst_n = 1'b1;
    base = pulse_n;
    fill(6, 8'h17);
    exp = ref_crc(6);
    send_pkt(6, 8'h17, 1'b1, 3, term);
    wait_cyc(term + 6);
    expect_pulse(base, term, exp, "R10 fresh packet");
    check_eq("R10 single pulse", 32'(pulse_n), 32'(base + 1));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule